// File: doc/BRIEF.md
# Teletext Page Table Manager

This block owns the page table of a teletext acquisition subsystem. Every hexadecimal page number from 100 to 8FF has one 16-bit entry. The entry holds a page-slot index and five status flags.

Acquisition logic reports each received page header as an event. The event carries the page number, its subcode, and whether the page data should be kept. The block marks the page as seen and gives it a fixed 1 kByte slot from a pool when asked. When the pool is empty, it replaces the lowest-priority unprotected resident page. The victim search walks the slots one per cycle.

The host uses the same command port for four things:
- reading an entry;
- rewriting an entry's host-visible flags;
- setting a page's 2-bit priority;
- acknowledging that the display memory was refreshed from a page.

The block keeps only the bookkeeping. It does not transfer page data.

Top module: `ttx_page_table`

## Requirements
- R1: Pages 100h..8FFh each own one entry; table row = page-800h for 800h..8FFh, else the page number itself. A request with a page outside that range completes with `rdata_o` = 0 and changes no entry.
- R2: Entry layout: bit 15 protect, bit 14 update, bit 13 subpage, bit 12 resident, bit 11 seen, bits 10..0 slot index in 1 kByte units. All entries and priorities reset to 0.
- R3: Every acquire event (`op_i`=1) on a valid page sets the seen flag, whether or not it is stored.
- R4: An acquire sets the subpage flag when `subcode_i` is neither 0000h nor 3F7Fh; otherwise the flag keeps its value.
- R5: A store request (`store_i`=1) for a non-resident page, while a slot is free, takes the lowest free slot index and sets the resident and update flags with that index.
- R6: A store request for a page already resident sets its update flag and keeps its slot index.
- R7: With no free slot, the block picks, among residents without protection, the one of lowest priority (ties: lowest slot index). If that priority is strictly below the incoming page's, the victim's resident flag is cleared (other bits kept), and the incoming page takes its slot with resident and update set.
- R8: A store request that cannot get a slot leaves resident, update and slot index unchanged. It still applies R3 and R4.
- R9: A page with its protect flag set is never chosen as a victim.
- R10: A display acknowledge (`op_i`=4) clears the page's update flag and nothing else.
- R11: A change command (`op_i`=2) copies `flags_i[4]`, `[3]`, `[2]` and `[0]` into protect, update, subpage and seen. The resident flag and the slot index are preserved.
- R12: A request is taken when `req_valid_i` is high and `busy_o` is low.
  - `done_o` is a one-cycle pulse that carries `rdata_o`, the entry after the operation.
  - It comes two cycles after acceptance, or NUM_SLOTS+3 cycles when a victim search runs.
  - `busy_o` is high from acceptance until the cycle before `done_o`.
- R13: A read command (`op_i`=0) returns the entry unchanged.
- R14: A priority command (`op_i`=3) stores `prio_i` for the page, returns the entry unchanged, and affects only victim selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe |
| op_i | input | 3 | 0 read, 1 acquire, 2 change, 3 priority, 4 display acknowledge |
| page_i | input | 12 | Page number |
| subcode_i | input | 16 | Page subcode for acquire |
| store_i | input | 1 | Acquire wants the page kept |
| flags_i | input | 5 | New flags for change |
| prio_i | input | 2 | New priority |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | Completion pulse |
| rdata_o | output | 16 | Resulting entry |

## Verification
The assertions rely on requests arriving only while `busy_o` is low. They also assume the request fields keep no meaning after acceptance, because the block latches them. They further assume no page reaches the resident state except through this block, so every slot owner is resident and differs from an incoming non-resident page. The stimulus raises `req_valid_i` for exactly one cycle after waiting for `busy_o` to drop. The only ways it touches the table are the five commands.

// File: rtl/ttx_pt_pkg.sv
package ttx_pt_pkg;
  localparam int PAGE_W  = 12;
  localparam int IDX_W   = 11;
  localparam int ENTRIES = 1 << IDX_W;
  localparam int PTR_W   = 11;

  typedef enum logic [2:0] {
    OP_READ   = 3'd0,
    OP_ACQ    = 3'd1,
    OP_CHANGE = 3'd2,
    OP_PRIO   = 3'd3,
    OP_ACK    = 3'd4
  } op_e;

  typedef struct packed {
    logic             prot;
    logic             upd;
    logic             sub;
    logic             mem;
    logic             cyc;
    logic [PTR_W-1:0] ptr;
  } entry_t;

  function automatic logic page_ok(input logic [PAGE_W-1:0] p);
    return (p >= 12'h100) && (p <= 12'h8FF);
  endfunction

  // 800..8FF fold onto rows 0..FF, 100..7FF map onto themselves
  function automatic logic [IDX_W-1:0] page_idx(input logic [PAGE_W-1:0] p);
    return p[11] ? {3'b000, p[7:0]} : p[10:0];
  endfunction

  function automatic logic sub_special(input logic [15:0] s);
    return (s != 16'h0000) && (s != 16'h3F7F);
  endfunction
endpackage

// File: rtl/ttx_pt_slot_pool.sv
module ttx_pt_slot_pool #(
  parameter int NUM_SLOTS = 8,
  parameter int SLOT_W    = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 alloc_i,
  output logic                 avail_o,
  output logic [SLOT_W-1:0]    slot_o,
  output logic [NUM_SLOTS-1:0] used_o
);
  logic [NUM_SLOTS-1:0] used_q;

  always_comb begin
    slot_o = '0;
    for (int s = NUM_SLOTS - 1; s >= 0; s--) begin
      if (!used_q[s]) slot_o = SLOT_W'(s);
    end
  end

  assign avail_o = ~&used_q;
  assign used_o  = used_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) used_q <= '0;
    else if (alloc_i && avail_o) used_q[slot_o] <= 1'b1;
  end
endmodule

// File: rtl/ttx_pt_victim_scan.sv
module ttx_pt_victim_scan #(
  parameter int NUM_SLOTS = 8,
  parameter int SLOT_W    = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              cand_ok_i,
  input  logic [1:0]        cand_pri_i,
  output logic [SLOT_W-1:0] idx_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              found_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic [1:0]        pri_o
);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(NUM_SLOTS - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_o   <= '0;
      busy_o  <= 1'b0;
      done_o  <= 1'b0;
      found_o <= 1'b0;
      slot_o  <= '0;
      pri_o   <= '0;
    end else if (start_i) begin
      idx_o   <= '0;
      busy_o  <= 1'b1;
      done_o  <= 1'b0;
      found_o <= 1'b0;
    end else if (busy_o) begin
      // strict less-than keeps the lowest slot on ties
      if (cand_ok_i && (!found_o || cand_pri_i < pri_o)) begin
        found_o <= 1'b1;
        slot_o  <= idx_o;
        pri_o   <= cand_pri_i;
      end
      if (idx_o == LAST) begin
        busy_o <= 1'b0;
        done_o <= 1'b1;
      end else begin
        idx_o <= idx_o + 1'b1;
      end
    end else begin
      done_o <= 1'b0;
    end
  end
endmodule

// File: rtl/ttx_page_table.sv
module ttx_page_table
  import ttx_pt_pkg::*;
#(
  parameter int NUM_SLOTS = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_valid_i,
  input  logic [2:0]  op_i,
  input  logic [11:0] page_i,
  input  logic [15:0] subcode_i,
  input  logic        store_i,
  input  logic [4:0]  flags_i,
  input  logic [1:0]  prio_i,
  output logic        busy_o,
  output logic        done_o,
  output logic [15:0] rdata_o
);
  localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;

  typedef enum logic [1:0] {S_IDLE, S_EXEC, S_SCAN} st_e;

  st_e              st;
  op_e              op_q;
  logic [IDX_W-1:0] idx_q;
  logic             ok_q;
  logic [15:0]      sub_q;
  logic             store_q;
  logic [4:0]       flags_q;
  logic [1:0]       prio_q;

  entry_t           tbl   [ENTRIES];
  logic [1:0]       pri   [ENTRIES];
  logic [IDX_W-1:0] owner [NUM_SLOTS];

  logic                 avail, alloc;
  logic [SLOT_W-1:0]    free_slot;
  logic [NUM_SLOTS-1:0] used;

  logic              scan_start, scan_busy, scan_done, scan_found;
  logic [SLOT_W-1:0] scan_idx, scan_slot;
  logic [1:0]        scan_pri;

  entry_t           cur, seen, new_ent, vic_ent;
  logic [IDX_W-1:0] vic_idx;
  logic             wr, go_scan, evict, finish;

  ttx_pt_slot_pool #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_pool (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .alloc_i (alloc),
    .avail_o (avail),
    .slot_o  (free_slot),
    .used_o  (used)
  );

  ttx_pt_victim_scan #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_scan (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (scan_start),
    .cand_ok_i  (!tbl[owner[scan_idx]].prot),
    .cand_pri_i (pri[owner[scan_idx]]),
    .idx_o      (scan_idx),
    .busy_o     (scan_busy),
    .done_o     (scan_done),
    .found_o    (scan_found),
    .slot_o     (scan_slot),
    .pri_o      (scan_pri)
  );

  assign cur     = tbl[idx_q];
  assign vic_idx = owner[scan_slot];
  assign vic_ent = tbl[vic_idx];

  always_comb begin
    seen     = cur;
    seen.cyc = 1'b1;
    if (sub_special(sub_q)) seen.sub = 1'b1;
    new_ent = cur;
    wr      = 1'b0;
    alloc   = 1'b0;
    go_scan = 1'b0;
    evict   = 1'b0;
    if (st == S_SCAN) begin
      new_ent = seen;
      wr      = scan_done;
      if (scan_done && scan_found && (scan_pri < pri[idx_q])) begin
        evict       = 1'b1;
        new_ent.mem = 1'b1;
        new_ent.upd = 1'b1;
        new_ent.ptr = PTR_W'(scan_slot);
      end
    end else if (st == S_EXEC && ok_q) begin
      case (op_q)
        OP_ACK: begin
          new_ent.upd = 1'b0;
          wr          = 1'b1;
        end
        OP_CHANGE: begin
          new_ent.prot = flags_q[4];
          new_ent.upd  = flags_q[3];
          new_ent.sub  = flags_q[2];
          new_ent.cyc  = flags_q[0];
          wr           = 1'b1;
        end
        OP_ACQ: begin
          new_ent = seen;
          if (store_q) begin
            if (cur.mem) begin
              new_ent.upd = 1'b1;
            end else if (avail) begin
              alloc       = 1'b1;
              new_ent.mem = 1'b1;
              new_ent.upd = 1'b1;
              new_ent.ptr = PTR_W'(free_slot);
            end else begin
              go_scan = 1'b1;
            end
          end
          wr = !go_scan;
        end
        default: ;
      endcase
    end
  end

  assign scan_start = go_scan;
  assign finish     = (st == S_EXEC && !go_scan) || (st == S_SCAN && scan_done);
  assign busy_o     = (st != S_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ENTRIES; i++) begin
        tbl[i] <= '0;
        pri[i] <= '0;
      end
      for (int s = 0; s < NUM_SLOTS; s++) owner[s] <= '0;
    end else begin
      if (wr) tbl[idx_q] <= new_ent;
      if (evict) begin
        tbl[vic_idx].mem  <= 1'b0;
        owner[scan_slot]  <= idx_q;
      end
      if (alloc) owner[free_slot] <= idx_q;
      if (st == S_EXEC && ok_q && op_q == OP_PRIO) pri[idx_q] <= prio_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st      <= S_IDLE;
      op_q    <= OP_READ;
      idx_q   <= '0;
      ok_q    <= 1'b0;
      sub_q   <= '0;
      store_q <= 1'b0;
      flags_q <= '0;
      prio_q  <= '0;
      done_o  <= 1'b0;
      rdata_o <= '0;
    end else begin
      done_o <= finish;
      case (st)
        S_IDLE: if (req_valid_i) begin
          op_q    <= op_e'(op_i);
          idx_q   <= page_idx(page_i);
          ok_q    <= page_ok(page_i);
          sub_q   <= subcode_i;
          store_q <= store_i;
          flags_q <= flags_i;
          prio_q  <= prio_i;
          st      <= S_EXEC;
        end
        S_EXEC: if (go_scan) st <= S_SCAN;
        default: ;
      endcase
      if (finish) begin
        st      <= S_IDLE;
        rdata_o <= ok_q ? new_ent : '0;
      end
    end
  end
endmodule

// File: rtl/ttx_page_table_chk.sv
module ttx_page_table_chk #(
  parameter int NUM_SLOTS = 8
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 busy_o,
  input logic                 done_o,
  input logic [15:0]          rdata_o,
  input logic [2:0]           op_q,
  input logic                 ok_q,
  input logic [NUM_SLOTS-1:0] used,
  input logic                 scan_start,
  input logic                 scan_busy,
  input logic                 scan_done,
  input logic                 scan_found,
  input logic                 vic_prot
);
  // R12
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R12
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  // R1
  bad_page_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !ok_q) |-> (rdata_o == 16'h0000));

  // R3
  seen_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && ok_q && op_q == 3'd1) |-> rdata_o[11]);

  // R10
  ack_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && ok_q && op_q == 3'd4) |-> !rdata_o[14]);

  // R5
  pool_grow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(used) == $countones($past(used))) ||
    ($countones(used) == $countones($past(used)) + 1));

  // R9
  victim_unprot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scan_done && scan_found) |-> !vic_prot);

  // R7
  scan_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scan_start |-> !scan_busy);
endmodule

bind ttx_page_table ttx_page_table_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .rdata_o    (rdata_o),
  .op_q       (op_q),
  .ok_q       (ok_q),
  .used       (used),
  .scan_start (scan_start),
  .scan_busy  (scan_busy),
  .scan_done  (scan_done),
  .scan_found (scan_found),
  .vic_prot   (vic_ent.prot)
);

// File: tb/tb_ttx_page_table.sv
module tb_ttx_page_table;
  localparam int N = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  op = '0;
  logic [11:0] page = '0;
  logic [15:0] sub = '0;
  logic        store = 1'b0;
  logic [4:0]  flags = '0;
  logic [1:0]  prio = '0;
  logic        busy, done;
  logic [15:0] rdata;

  int n_checks = 0;
  int n_fail   = 0;

  logic [15:0] m_ent [2048];
  logic [1:0]  m_pri [2048];
  int          m_own [N];
  int          m_used;

  always #2 clk = ~clk;

  ttx_page_table #(.NUM_SLOTS(N)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .op_i(op),
    .page_i(page), .subcode_i(sub), .store_i(store), .flags_i(flags),
    .prio_i(prio), .busy_o(busy), .done_o(done), .rdata_o(rdata)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit in_range(input logic [11:0] p);
    return p >= 12'h100 && p <= 12'h8FF;
  endfunction

  function automatic int row(input logic [11:0] p);
    return (p >= 12'h800) ? int'(p) - 'h800 : int'(p);
  endfunction

  // issue one request, return result and negedges from acceptance to done
  task automatic issue(input logic [2:0] o, input logic [11:0] p, input logic [15:0] s,
                       input logic st, input logic [4:0] f, input logic [1:0] pr,
                       output logic [15:0] res, output int lat);
    @(negedge clk);
    while (busy) @(negedge clk);
    op = o; page = p; sub = s; store = st; flags = f; prio = pr;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R12", {15'd0, busy}, 16'd1);
    lat = 0;
    while (!done && lat < 1000) begin
      @(negedge clk);
      lat++;
    end
    res = rdata;
  endtask

  task automatic do_op(input logic [2:0] o, input logic [11:0] p, input logic [15:0] s,
                       input logic st, input logic [4:0] f, input logic [1:0] pr,
                       output logic [15:0] res);
    logic [15:0] e, exp;
    string tag;
    bit scan;
    int r, lat, best;
    logic [1:0] bp;
    scan = 0;
    tag  = "R13";
    exp  = 16'h0000;
    if (!in_range(p)) begin
      tag = "R1";
    end else begin
      r = row(p);
      e = m_ent[r];
      case (o)
        3'd1: begin
          tag = "R3";
          e[11] = 1'b1;
          if (s != 16'h0000 && s != 16'h3F7F) e[13] = 1'b1;
          if (st) begin
            if (e[12]) begin
              e[14] = 1'b1; tag = "R6";
            end else if (m_used < N) begin
              m_own[m_used] = r;
              e[12] = 1'b1; e[14] = 1'b1; e[10:0] = 11'(m_used);
              m_used++; tag = "R5";
            end else begin
              scan = 1; best = -1; bp = 2'd0;
              for (int k = 0; k < N; k++) begin
                if (!m_ent[m_own[k]][15] && (best < 0 || m_pri[m_own[k]] < bp)) begin
                  best = k; bp = m_pri[m_own[k]];
                end
              end
              if (best >= 0 && bp < m_pri[r]) begin
                m_ent[m_own[best]][12] = 1'b0;
                m_own[best] = r;
                e[12] = 1'b1; e[14] = 1'b1; e[10:0] = 11'(best);
                tag = "R7";
              end else begin
                tag = "R8";
              end
            end
          end
        end
        3'd2: begin
          e[15] = f[4]; e[14] = f[3]; e[13] = f[2]; e[11] = f[0];
          tag = "R11";
        end
        3'd3: begin
          m_pri[r] = pr; tag = "R14";
        end
        3'd4: begin
          e[14] = 1'b0; tag = "R10";
        end
        default: ;
      endcase
      m_ent[r] = e;
      exp = e;
    end
    issue(o, p, s, st, f, pr, res, lat);
    chk(tag, res, exp);
    chk("R12", 16'(lat), scan ? 16'(N + 2) : 16'd1);
  endtask

  logic [15:0] res;

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 2048; i++) begin m_ent[i] = '0; m_pri[i] = '0; end
    for (int k = 0; k < N; k++) m_own[k] = 0;
    m_used = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12", {14'd0, busy, done}, 16'd0);
    chk("R2", rdata, 16'd0);

    do_op(3'd0, 12'h800, 0, 0, 0, 0, res);             // R13
    do_op(3'd1, 12'h800, 16'h0000, 1, 0, 0, res);
    chk("R2", res, 16'h5800);
    do_op(3'd1, 12'h100, 16'h3F7F, 1, 0, 0, res);
    chk("R4", {15'd0, res[13]}, 16'd0);
    do_op(3'd1, 12'h123, 16'h0005, 1, 0, 0, res);
    chk("R4", {15'd0, res[13]}, 16'd1);
    do_op(3'd1, 12'h800, 16'h0000, 1, 0, 0, res);      // R6
    do_op(3'd1, 12'h7FF, 16'h0000, 0, 0, 0, res);
    chk("R3", res, 16'h0800);
    do_op(3'd1, 12'h8FF, 16'h0000, 1, 0, 0, res);      // pool now full
    do_op(3'd4, 12'h800, 0, 0, 0, 0, res);             // R10
    do_op(3'd3, 12'h800, 0, 0, 0, 2'd1, res);
    do_op(3'd3, 12'h123, 0, 0, 0, 2'd2, res);
    do_op(3'd1, 12'h456, 16'h0001, 1, 0, 0, res);      // R8: nothing lower
    do_op(3'd3, 12'h456, 0, 0, 0, 2'd2, res);
    do_op(3'd1, 12'h456, 16'h0001, 1, 0, 0, res);      // R7: tie, slot 1
    chk("R7", {5'd0, res[10:0]}, 16'd1);
    do_op(3'd0, 12'h100, 0, 0, 0, 0, res);
    chk("R7", res, 16'h4801);
    do_op(3'd2, 12'h8FF, 0, 0, 5'b11011, 0, res);      // R11
    do_op(3'd3, 12'h555, 0, 0, 0, 2'd3, res);
    do_op(3'd1, 12'h555, 16'h0000, 1, 0, 0, res);      // R7 victim slot 0
    for (int k = 0; k < 3; k++) begin
      logic [11:0] pg;
      pg = (k == 0) ? 12'h555 : (k == 1) ? 12'h456 : 12'h123;
      do_op(3'd2, pg, 0, 0, 5'b10001, 0, res);
    end
    do_op(3'd3, 12'h600, 0, 0, 0, 2'd3, res);
    do_op(3'd1, 12'h600, 16'h0000, 1, 0, 0, res);      // R9: all protected
    chk("R9", {15'd0, res[12]}, 16'd0);
    do_op(3'd0, 12'h8FF, 0, 0, 0, 0, res);
    chk("R9", {15'd0, res[12]}, 16'd1);
    do_op(3'd1, 12'h0FF, 16'h0001, 1, 0, 0, res);      // R1
    do_op(3'd2, 12'h900, 0, 0, 5'b11111, 0, res);
    do_op(3'd0, 12'hFFF, 0, 0, 0, 0, res);
    do_op(3'd3, 12'h000, 0, 0, 0, 2'd3, res);

    for (int i = 0; i < 240; i++) begin
      int k;
      logic [11:0] pg;
      logic [15:0] sc;
      k  = (i * 7) % 24;
      pg = (k < 8) ? 12'(12'h800 + k * 33) : 12'(12'h100 + k * 71);
      sc = (i % 4 == 0) ? 16'h0000 : (i % 4 == 1) ? 16'h3F7F : 16'(i * 13);
      case (i % 6)
        0, 1, 2: do_op(3'd1, pg, sc, (i % 3) != 2, 0, 0, res);
        3:       do_op(3'd3, pg, 0, 0, 0, 2'((i * 5) % 4), res);
        4:       do_op(3'd2, pg, 0, 0, (i % 5 == 0) ? 5'b10001 : 5'b01101, 0, res);
        default: do_op((i % 12 == 5) ? 3'd4 : 3'd0, pg, 0, 0, 0, 0, res);
      endcase
    end

    for (int p = 'h100; p <= 'h8FF; p++) begin
      int lat;
      issue(3'd0, 12'(p), 0, 0, 0, 0, res, lat);
      chk("R1", res, m_ent[row(12'(p))]);
    end

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule